// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Source Codes

This block collects level-sensitive interrupt requests from a set of on-chip sources and one non-maskable input. It then offers a single winner to the CPU. Each source has a 5-bit priority in a small configuration bank. The arbiter picks the asserted source with the highest priority and drops that priority's least significant bit to form a 4-bit request level. It offers the level together with a code that is unique to the source. A request level of zero means nothing is requested.

The offer goes out only if its level is above the CPU's current mask level and the CPU's block bit is clear. The non-maskable input ignores both of these conditions and beats every source. Requests pass through a fixed-depth delay line before arbitration, which models the time needed to settle priority.

Once an offer is out, it is held until the CPU acknowledges it. On the acknowledge, the code is latched into an event register. If the offered source has withdrawn its request by then, the latched code is zero. That is a spurious acceptance, and software simply returns from it. When a non-maskable offer is acknowledged, a mode input decides whether the CPU is told to raise its mask to 15.

Top module: `irqc_top`

## Requirements
- R1: After reset every priority register reads 0. A write at an address below NSRC stores the 5-bit value, and `cfg_rdata` returns the register that `cfg_addr` selects. Addresses at or above NSRC read 0, and writes to them change nothing.
- R2: Among the asserted sources, the one with the highest 5-bit priority wins. When two or more share that priority, the lowest index wins.
- R3: The request level is bits [4:1] of the winner's priority. A level of 0 means no request, so sources with priority 0 or 1 are never offered.
- R4: A source offer is made only if its level is strictly greater than `cpu_imask` and `cpu_blk` is 0. Otherwise `irq_level` and `irq_code` are both 0.
- R5: A source with index i is offered with code 0x400 + 0x20*i. An asserted `nmi_req` beats every source and ignores the mask and the block bit. It is offered with `irq_nmi`=1, level 15 and code 0x1C0.
- R6: A change on `src_req` or `nmi_req` reaches the outputs exactly DLY+1 clock edges later, which is 3 by default. Before that edge the old offer is still shown.
- R7: While an offer is out and not acknowledged, `irq_level`, `irq_code` and `irq_nmi` hold steady, whatever the mask, the block bit or the requests do. An acknowledge clears the offer for one cycle, and the offer then reloads.
- R8: An acknowledge of an offer latches into `evt_code` the offered code if that source is still asserted at the end of the delay line, and 0 if it has withdrawn. An acknowledge with no offer out leaves `evt_code` unchanged.
- R9: `imask_force` pulses for one cycle after a non-maskable offer is acknowledged, but only if `nmi_mask_mode` is 1. It never pulses otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Priority register write strobe |
| cfg_addr | input | $clog2(NSRC) | Priority register select |
| cfg_wdata | input | 5 | Priority write value |
| cfg_rdata | output | 5 | Selected priority register |
| src_req | input | NSRC | Level requests from the sources |
| nmi_req | input | 1 | Non-maskable request level |
| cpu_imask | input | 4 | CPU current mask level |
| cpu_blk | input | 1 | CPU block-interrupts bit |
| nmi_mask_mode | input | 1 | 1: a non-maskable acceptance forces the mask to 15 |
| irq_level | output | 4 | Offered request level (0 = none) |
| irq_code | output | 12 | Offered source code |
| irq_nmi | output | 1 | The offer is the non-maskable one |
| irq_ack | input | 1 | CPU accepts the current offer |
| evt_code | output | 12 | Code latched on acceptance |
| imask_force | output | 1 | One-cycle command to set the CPU mask to 15 |

## Verification
A request pattern shows at the offer outputs on the third clock edge after it is applied. The bench checks for no offer after two edges and for the expected offer after the third. Results of an acknowledge (the event code and the mask-force pulse) are due one edge after the acknowledge is sampled and are read at the following falling edge. For a spurious acceptance, the bench waits two edges after the withdrawal before it acknowledges, so that the withdrawal has reached the end of the delay line. Every sample is taken on the falling edge, and the bench gets back to idle before each new pattern so that no offer left from the previous one is held.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int PRIO_W = 5;
    localparam int LVL_W  = 4;
    localparam int CODE_W = 12;
    localparam int IDX_W  = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam code_t NMI_CODE  = 12'h1C0;
    localparam code_t CODE_BASE = 12'h400;
    localparam code_t CODE_STEP = 12'h020;
    localparam lvl_t  LVL_TOP   = 4'hF;

    // arbitration winner
    typedef struct packed {
        logic  hit;
        idx_t  idx;
        prio_t prio;
    } pick_t;

    // what is being offered to the CPU
    typedef struct packed {
        logic  nmi;
        lvl_t  lvl;
        code_t code;
        idx_t  idx;
    } offer_t;

    function automatic code_t src_code(input idx_t i);
        return CODE_BASE + code_t'(i) * CODE_STEP;
    endfunction

    function automatic lvl_t prio_to_lvl(input prio_t p);
        return p[PRIO_W-1:1];
    endfunction
endpackage

// File: rtl/irqc_prio_regs.sv
module irqc_prio_regs
    import irqc_pkg::*;
#(
    parameter int NSRC = 14,
    parameter int AW   = $clog2(NSRC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  prio_t         wdata,
    output prio_t         rdata,
    output prio_t         prio_o [NSRC]
);
    for (genvar g = 0; g < NSRC; g++) begin : g_reg
        prio_t r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (we && addr == AW'(g))
                r <= wdata;
        end
        assign prio_o[g] = r;

        // R1: a write to this slot is visible on the next cycle
        a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
            (we && addr == AW'(g)) |=> (prio_o[g] == $past(wdata)));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSRC; i++)
            if (addr == AW'(i))
                rdata = prio_o[i];
    end
endmodule

// File: rtl/irqc_req_delay.sv
module irqc_req_delay #(
    parameter int W     = 15,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '0;
                else     st[0] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) st[s] <= '0;
                else     st[s] <= st[s-1];
            end
        end
    end

    assign q = st[DEPTH-1];
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NSRC = 14
) (
    input  logic [NSRC-1:0] pend,
    input  prio_t           prio [NSRC],
    output pick_t           pick
);
    // strict compare keeps the lower index on a tie
    always_comb begin
        pick = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!pick.hit || prio[i] > pick.prio)) begin
                pick.hit  = 1'b1;
                pick.idx  = idx_t'(i);
                pick.prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC = 14,
    parameter int DLY  = 2,
    parameter int AW   = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [4:0]      cfg_wdata,
    output logic [4:0]      cfg_rdata,
    input  logic [NSRC-1:0] src_req,
    input  logic            nmi_req,
    input  logic [3:0]      cpu_imask,
    input  logic            cpu_blk,
    input  logic            nmi_mask_mode,
    output logic [3:0]      irq_level,
    output logic [11:0]     irq_code,
    output logic            irq_nmi,
    input  logic            irq_ack,
    output logic [11:0]     evt_code,
    output logic            imask_force
);
    localparam int PADW = 2 ** AW;

    prio_t           prio [NSRC];
    logic [NSRC:0]   req_d;
    logic [NSRC-1:0] pend_d;
    logic            nmi_d;
    logic [PADW-1:0] pend_pad;
    pick_t           pick;
    offer_t          cand;
    offer_t          offer_q;
    code_t           evt_q;
    logic            force_q;
    logic            busy;
    logic            still_up;
    lvl_t            pick_lvl;

    irqc_prio_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .prio_o(prio)
    );

    // the non-maskable level rides in the top bit of the same delay line
    irqc_req_delay #(.W(NSRC + 1), .DEPTH(DLY)) u_dly (
        .clk(clk),
        .rst(rst),
        .d  ({nmi_req, src_req}),
        .q  (req_d)
    );

    assign pend_d = req_d[NSRC-1:0];
    assign nmi_d  = req_d[NSRC];

    irqc_arbiter #(.NSRC(NSRC)) u_arb (
        .pend(pend_d),
        .prio(prio),
        .pick(pick)
    );

    assign pick_lvl = prio_to_lvl(pick.prio);

    always_comb begin
        cand = '0;
        if (nmi_d) begin
            cand.nmi  = 1'b1;
            cand.lvl  = LVL_TOP;
            cand.code = NMI_CODE;
        end else if (pick.hit && pick_lvl > cpu_imask && !cpu_blk) begin
            cand.lvl  = pick_lvl;
            cand.code = src_code(pick.idx);
            cand.idx  = pick.idx;
        end
    end

    always_comb begin
        pend_pad = '0;
        pend_pad[NSRC-1:0] = pend_d;
    end

    assign busy     = offer_q.nmi || (offer_q.lvl != '0);
    assign still_up = offer_q.nmi ? nmi_d : pend_pad[offer_q.idx[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            offer_q <= '0;
            evt_q   <= '0;
            force_q <= 1'b0;
        end else begin
            force_q <= 1'b0;
            if (busy && irq_ack) begin
                evt_q   <= still_up ? offer_q.code : '0;
                force_q <= offer_q.nmi && nmi_mask_mode;
                offer_q <= '0;
            end else if (!busy) begin
                offer_q <= cand;
            end
        end
    end

    assign irq_level   = offer_q.lvl;
    assign irq_code    = offer_q.code;
    assign irq_nmi     = offer_q.nmi;
    assign evt_code    = evt_q;
    assign imask_force = force_q;

    // R2: the winner is always one of the pending sources
    a_r2_pick_pending: assert property (@(posedge clk) disable iff (rst)
        pick.hit |-> pend_pad[pick.idx[AW-1:0]]);

    // R4: a freshly loaded source offer respected the mask and block bit
    a_r4_gate: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (irq_nmi || irq_level == '0 ||
                   (!$past(cpu_blk) && irq_level > $past(cpu_imask))));

    // R5: the non-maskable offer carries its fixed level and code
    a_r5_nmi_offer: assert property (@(posedge clk) disable iff (rst)
        irq_nmi |-> (irq_level == LVL_TOP && irq_code == NMI_CODE));

    // R7: an unanswered offer does not move
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !irq_ack) |=> $stable({irq_level, irq_code, irq_nmi}));

    // R7: acceptance empties the offer for a cycle
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (busy && irq_ack) |=> (irq_level == '0 && !irq_nmi));

    // R8: the event register only moves on an accepted offer
    a_r8_evt_keep: assert property (@(posedge clk) disable iff (rst)
        !(busy && irq_ack) |=> $stable(evt_code));

    // R9: mask force only after an accepted non-maskable offer in force mode
    a_r9_force_cause: assert property (@(posedge clk) disable iff (rst)
        imask_force |-> $past(irq_nmi && irq_ack && nmi_mask_mode));

    a_r9_force_due: assert property (@(posedge clk) disable iff (rst)
        (irq_nmi && irq_ack && nmi_mask_mode) |=> imask_force);
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    localparam int NS  = 14;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [3:0]    cfg_addr;
    logic [4:0]    cfg_wdata;
    logic [4:0]    cfg_rdata;
    logic [NS-1:0] src_req;
    logic          nmi_req;
    logic [3:0]    cpu_imask;
    logic          cpu_blk;
    logic          nmi_mask_mode;
    logic [3:0]    irq_level;
    logic [11:0]   irq_code;
    logic          irq_nmi;
    logic          irq_ack;
    logic [11:0]   evt_code;
    logic          imask_force;

    always #2 clk = ~clk;

    irqc_top #(.NSRC(NS), .DLY(2)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_req(src_req),
        .nmi_req(nmi_req), .cpu_imask(cpu_imask), .cpu_blk(cpu_blk),
        .nmi_mask_mode(nmi_mask_mode), .irq_level(irq_level),
        .irq_code(irq_code), .irq_nmi(irq_nmi), .irq_ack(irq_ack),
        .evt_code(evt_code), .imask_force(imask_force)
    );

    int nvec = 0;
    int nbad = 0;
    bit done = 0;
    logic [4:0]  mp [16];
    logic [11:0] exp_evt;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // {level, code} expected for a request pattern
    function automatic logic [15:0] model(input logic [NS-1:0] rq, input logic [3:0] mk, input logic b);
        int bi = -1;
        logic [4:0] bp = '0;
        for (int i = 0; i < NS; i++)
            if (rq[i] && (bi < 0 || mp[i] > bp)) begin
                bi = i;
                bp = mp[i];
            end
        if (bi < 0 || bp[4:1] == 4'd0 || bp[4:1] <= mk || b)
            return 16'h0;
        return {bp[4:1], 12'h400 + 12'(bi) * 12'h020};
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [4:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
        if (int'(a) < NS) mp[a] = d;
    endtask

    task automatic clear();
        src_req = '0; nmi_req = 1'b0;
        step(LAT + 1);
        if (irq_level != 4'd0 || irq_nmi) begin
            irq_ack = 1'b1;
            step(1);
            irq_ack = 1'b0;
            exp_evt = 12'h0;
        end
        step(2);
    endtask

    task automatic ack_check(input string tag, input logic [11:0] e, input logic f);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        chk({tag, " evt"}, evt_code, e);
        chk({tag, " force"}, imask_force, f);
        exp_evt = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [15:0] e;
        void'($urandom(32'd1177));
        for (int i = 0; i < 16; i++) mp[i] = '0;
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; src_req = 0;
        nmi_req = 0; cpu_imask = 0; cpu_blk = 0; nmi_mask_mode = 0; irq_ack = 0;
        exp_evt = 0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state and readback
        chk("R1 reset level", irq_level, 0);
        chk("R1 reset code", irq_code, 0);
        chk("R1 reset evt", evt_code, 0);
        for (int a = 0; a < 16; a++) begin
            cfg_addr = 4'(a);
            #1 chk("R1 reset rdata", cfg_rdata, 0);
        end
        for (int a = 0; a < 16; a++) wr(4'(a), 5'(a + 9));
        for (int a = 0; a < 16; a++) begin
            cfg_addr = 4'(a);
            #1 chk("R1 readback/out-of-range", cfg_rdata, (a < NS) ? 5'(a + 9) : 5'd0);
        end

        // R3: priority 1 is never offered
        for (int a = 0; a < NS; a++) wr(4'(a), 5'd0);
        wr(4'd2, 5'd1);
        src_req = 14'b100;
        step(LAT);
        chk("R3 prio1 masked", irq_level, 0);
        clear();

        // R2 tie: sources 5 and 9 equal, lowest index wins
        wr(4'd5, 5'd22); wr(4'd9, 5'd22); wr(4'd11, 5'd21);
        src_req = '0; src_req[9] = 1; src_req[5] = 1; src_req[11] = 1;
        step(LAT - 1);
        chk("R6 not yet", irq_level, 0);
        step(1);
        chk("R2 tie level", irq_level, 4'd11);
        chk("R5 tie code", irq_code, 12'h4A0);
        // R7 hold under mask/block change
        cpu_imask = 4'hF; cpu_blk = 1'b1; src_req[5] = 0;
        step(1);
        chk("R7 hold level", irq_level, 4'd11);
        chk("R7 hold code", irq_code, 12'h4A0);
        cpu_imask = 0; cpu_blk = 0; src_req[5] = 1;
        step(2);
        ack_check("R8 accept", 12'h4A0, 1'b0);
        chk("R7 cleared after ack", irq_level, 0);
        clear();

        // R8 spurious: request withdrawn before acceptance
        wr(4'd3, 5'd20);
        src_req = 14'b1000;
        step(LAT);
        chk("R4 offer", irq_level, 4'd10);
        src_req = '0;
        step(2);
        chk("R7 held after withdraw", irq_code, 12'h460);
        ack_check("R8 spurious", 12'h000, 1'b0);
        clear();

        // R8 ack with nothing offered
        wr(4'd7, 5'd14);
        src_req = '0; src_req[7] = 1;
        step(LAT);
        ack_check("R8 set", 12'h4E0, 1'b0);
        clear();
        wr(4'd7, 5'd14);
        src_req = '0; src_req[7] = 1;
        step(LAT);
        ack_check("R8 set again", 12'h4E0, 1'b0);
        src_req = '0;
        step(LAT + 1);
        if (irq_level != 0) begin irq_ack = 1; step(1); irq_ack = 0; end
        step(2);
        chk("R8 spurious baseline", evt_code, 12'h0);
        irq_ack = 1; step(1); irq_ack = 0;
        chk("R8 idle ack ignored", evt_code, 12'h0);
        chk("R9 idle no force", imask_force, 0);
        exp_evt = 0;

        // R5/R9: non-maskable beats blocked sources, with force mode
        wr(4'd0, 5'd31);
        src_req = 14'b1; nmi_req = 1; cpu_blk = 1; cpu_imask = 4'hF; nmi_mask_mode = 1;
        step(LAT);
        chk("R5 nmi flag", irq_nmi, 1);
        chk("R5 nmi level", irq_level, 4'hF);
        chk("R5 nmi code", irq_code, 12'h1C0);
        ack_check("R9 nmi force", 12'h1C0, 1'b1);
        step(1);
        chk("R9 pulse one cycle", imask_force, 0);
        nmi_mask_mode = 0;
        clear();
        nmi_req = 1;
        step(LAT);
        ack_check("R9 nmi no force", 12'h1C0, 1'b0);
        cpu_blk = 0; cpu_imask = 0;
        clear();

        // random patterns checked against the model
        for (int t = 0; t < 300; t++) begin
            logic [NS-1:0] rq;
            logic [3:0] mk;
            logic b;
            for (int k = 0; k < 3; k++) wr(4'($urandom % NS), 5'($urandom));
            rq = NS'($urandom) & NS'($urandom);
            mk = 4'($urandom % 8);
            b  = ($urandom % 8) == 0;
            src_req = rq; cpu_imask = mk; cpu_blk = b;
            e = model(rq, mk, b);
            step(LAT - 1);
            chk("R6 latency early", irq_level, 0);
            step(1);
            chk("R2/R3/R4 level", irq_level, e[15:12]);
            chk("R5 code", irq_code, e[11:0]);
            if (e != 0) ack_check("R8 random accept", e[11:0], 1'b0);
            else begin
                irq_ack = 1; step(1); irq_ack = 0;
                chk("R8 random idle ack", evt_code, exp_evt);
            end
            cpu_blk = 0;
            clear();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule